// File: doc/BRIEF.md
# Ring Resonator Wavelength Lock Controller

This block keeps a thermally tuned ring modulator parked at a chosen point on the slope of its resonance. It has one actuator, a heater code sent to a DAC, and one feedback signal, a digitized photocurrent sample that arrives on a valid/ready stream. On each accepted sample the controller may move the heater code. After enable it first sweeps the whole heater range in coarse steps to find the resonance dip. It then parks a fixed detuning above the dip, takes a reference photocurrent, and tracks slow thermal drift by moving the code one step at a time.

An abrupt change of photocurrent means the resonance has jumped. The controller then searches a narrow window around its present code and falls back to a full sweep if the dip is not found there. Loss of light and a heater pinned at the top of its range are both faults. In either fault the heater code is forced to zero. A dark fault clears by itself once light has been back for a while, and the controller then calibrates again. A heater fault waits for an explicit clear. A short brownout is absorbed: dark samples shorter than the debounce length freeze the loop, and the small resonance shift that follows is retuned like drift.

Stream rules: `sample_ready` equals `enable`, so the controller never applies back-pressure while it is running. A sample counts only in a cycle where both `sample_valid` and `sample_ready` are high. Cycles without a sample leave the state and the heater code unchanged. A sample accepted at a clock edge is taken as the response to the heater code shown during that cycle.

Top module: `ring_lock_ctrl`

## Requirements
- R1: While reset is asserted, or at any clock edge where `enable` is low, the state becomes RESET, `dac_code` is 0, `sample_ready` is low and all three flags are low. The first edge with `enable` high in RESET moves the state to CALIBRATE with code 0.
- R2: A sample is consumed only when `sample_valid` and `sample_ready` are both high. `sample_ready` follows `enable`. In CALIBRATE, LOCK, MONITOR and RELOCK, a cycle without a consumed sample leaves `state_o` and `dac_code` unchanged.
- R3: CALIBRATE applies codes 0, CAL_STEP, 2·CAL_STEP, … up to the last code not above full scale, one per lit sample. It keeps the first code that shows the lowest sample. After the last code it enters LOCK with the code set to that minimum code plus DETUNE, saturated at full scale.
- R4: LOCK holds its code for SETTLE lit samples. The last of these becomes the reference, and the state becomes MONITOR. `locked` is high exactly in MONITOR.
- R5: In MONITOR, a lit sample more than DEADBAND below the reference raises the code by 1. A lit sample more than DEADBAND above the reference lowers it by 1. Neither step goes past the ends of the range, and the state stays MONITOR. A steady input leaves the code fixed for as long as it lasts.
- R6: In MONITOR, a lit sample that differs from the reference by more than JUMP_TH enters RELOCK. RELOCK then sweeps codes one by one from (code − WIN) up to (code + WIN), clamped to 0 and full scale.
- R7: When the RELOCK window is done and its lowest sample is at most the calibration minimum plus RELOCK_TOL, the code becomes that sample's code plus DETUNE, saturated at full scale. After SETTLE lit samples a new reference is taken and the state returns to MONITOR.
- R8: When the RELOCK window is done without meeting the R7 test, the state falls back to CALIBRATE with code 0 and a fresh sweep.
- R9: A sample below DARK_TH is dark. In CALIBRATE, LOCK, MONITOR or RELOCK, DARK_CNT consecutive dark samples enter FAULT with `fault_dark` high and code 0. Fewer than DARK_CNT dark samples change neither the state nor the code.
- R10: In a dark fault, DARK_CNT consecutive lit samples move the state to CALIBRATE with code 0.
- R11: In MONITOR at full-scale code, FS_CNT consecutive lit samples asking for a higher code (and not a jump) enter FAULT with `fault_heater` high and code 0. This fault remains while light is present. `fault_clear` in any fault moves the state to RESET.
- R12: `state_o` encoding: RESET 0, CALIBRATE 1, LOCK 2, MONITOR 3, RELOCK 4, FAULT 5. In FAULT `dac_code` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the control loop; low forces RESET |
| sample_valid | input | 1 | Photocurrent sample is valid |
| sample_ready | output | 1 | Controller accepts a sample (equals enable) |
| sample_data | input | ADC_W | Digitized photocurrent |
| fault_clear | input | 1 | Leave FAULT for RESET |
| dac_code | output | DAC_W | Heater DAC code |
| state_o | output | 3 | Controller state (encoding in R12) |
| locked | output | 1 | High in MONITOR |
| fault_dark | output | 1 | In FAULT because light was lost |
| fault_heater | output | 1 | In FAULT because the heater hit full scale |

## Verification
The bench closes the loop with a V-shaped resonance model whose dip position, floor level and presence of light it controls. Calibration is run with the dip at every code position, including ties between two sweep codes and dips near either end of the range. This separates correct minimum selection, tie order and detune saturation. Drift of one code in each direction is told apart from a jump, and a jump whose dip lies inside the window is told apart from one outside it and from one that hits the clamped top of the window. Short and long dark spells, and a heater pinned at full scale, show whether the debounce and the two fault exits behave as stated.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_CAL    = 3'd1,
    ST_LOCK   = 3'd2,
    ST_MON    = 3'd3,
    ST_RELOCK = 3'd4,
    ST_FAULT  = 3'd5
  } rlc_state_e;
endpackage

// File: rtl/rlc_debounce.sv
// Counts consecutive qualifying samples; hit marks the LEN-th one in a row.
module rlc_debounce #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic cond,
  output logic hit
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  assign hit = step && cond && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (step) begin
      if (!cond)               cnt_q <= '0;
      else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rlc_min_track.sv
// Tracks the first code that produced the lowest sample of a sweep.
// best_* already include the sample offered in the current cycle.
module rlc_min_track #(
  parameter int DAC_W = 6,
  parameter int ADC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             update,
  input  logic [DAC_W-1:0] code,
  input  logic [ADC_W-1:0] sample,
  output logic [DAC_W-1:0] best_code,
  output logic [ADC_W-1:0] best_val
);
  logic [DAC_W-1:0] code_q;
  logic [ADC_W-1:0] val_q;
  logic             better;

  assign better    = update && (sample < val_q);
  assign best_code = better ? code   : code_q;
  assign best_val  = better ? sample : val_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      code_q <= '0;
      val_q  <= '1;
    end else if (better) begin
      code_q <= code;
      val_q  <= sample;
    end
  end
endmodule

// File: rtl/ring_lock_ctrl.sv
module ring_lock_ctrl
  import rlc_pkg::*;
#(
  parameter int DAC_W      = 6,
  parameter int ADC_W      = 8,
  parameter int CAL_STEP   = 4,
  parameter int DETUNE     = 3,
  parameter int DARK_TH    = 10,
  parameter int DARK_CNT   = 3,
  parameter int FS_CNT     = 4,
  parameter int DEADBAND   = 1,
  parameter int JUMP_TH    = 10,
  parameter int WIN        = 6,
  parameter int SETTLE     = 2,
  parameter int RELOCK_TOL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sample_valid,
  output logic             sample_ready,
  input  logic [ADC_W-1:0] sample_data,
  input  logic             fault_clear,
  output logic [DAC_W-1:0] dac_code,
  output logic [2:0]       state_o,
  output logic             locked,
  output logic             fault_dark,
  output logic             fault_heater
);
  localparam int EW = ADC_W + 2;
  localparam int CW = DAC_W + 1;
  localparam int SW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [DAC_W-1:0] DMAX     = '1;
  localparam logic [CW-1:0]    DMAX_E   = {1'b0, DMAX};
  localparam logic [CW-1:0]    STEP_E   = CW'(CAL_STEP);
  localparam logic [CW-1:0]    DET_E    = CW'(DETUNE);
  localparam logic [CW-1:0]    WIN_E    = CW'(WIN);
  localparam logic [EW-1:0]    DB_E     = EW'(DEADBAND);
  localparam logic [EW-1:0]    JMP_E    = EW'(JUMP_TH);
  localparam logic [EW-1:0]    TOL_E    = EW'(RELOCK_TOL);
  localparam logic [ADC_W-1:0] DARK_LVL = ADC_W'(DARK_TH);
  localparam logic [SW-1:0]    SET_LAST = SW'(SETTLE - 1);

  function automatic logic [DAC_W-1:0] add_sat(input logic [DAC_W-1:0] c,
                                               input logic [CW-1:0] a);
    logic [CW-1:0] t;
    t = {1'b0, c} + a;
    return (t > DMAX_E) ? DMAX : t[DAC_W-1:0];
  endfunction

  // ---------------- state ----------------
  rlc_state_e       state_q, state_d;
  logic [DAC_W-1:0] dac_q, dac_d;
  logic [ADC_W-1:0] ref_q, ref_d;
  logic [ADC_W-1:0] calmin_q, calmin_d;
  logic [DAC_W-1:0] winhi_q, winhi_d;
  logic [SW-1:0]    cnt_q, cnt_d;
  logic             settle_q, settle_d;
  logic             heat_q, heat_d;
  logic             trk_clr;

  // ---------------- sample qualification ----------------
  logic             acc, dark, lit_state;
  logic [EW-1:0]    s_e, r_e;
  logic             above, below, jump;
  logic             dark_hit, light_hit, fs_hit;
  logic [DAC_W-1:0] best_code;
  logic [ADC_W-1:0] best_val;
  logic             trk_upd;
  logic             cal_last, relock_ok;
  logic [DAC_W-1:0] win_lo;
  logic [DAC_W-1:0] win_hi;

  assign sample_ready = enable;
  assign acc          = sample_valid && sample_ready;
  assign dark         = sample_data < DARK_LVL;
  assign lit_state    = (state_q == ST_CAL) || (state_q == ST_LOCK) ||
                        (state_q == ST_MON) || (state_q == ST_RELOCK);

  assign s_e   = EW'(sample_data);
  assign r_e   = EW'(ref_q);
  assign above = s_e > (r_e + DB_E);
  assign below = (s_e + DB_E) < r_e;
  assign jump  = (s_e > (r_e + JMP_E)) || ((s_e + JMP_E) < r_e);

  assign cal_last  = ({1'b0, dac_q} + STEP_E) > DMAX_E;
  assign relock_ok = EW'(best_val) <= (EW'(calmin_q) + TOL_E);
  assign win_lo    = ({1'b0, dac_q} >= WIN_E) ? (dac_q - WIN_E[DAC_W-1:0]) : '0;
  assign win_hi    = add_sat(dac_q, WIN_E);

  assign trk_upd = acc && !dark &&
                   ((state_q == ST_CAL) || ((state_q == ST_RELOCK) && !settle_q));

  rlc_debounce #(.LEN(DARK_CNT)) u_dark_db (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .step(acc),
    .cond(lit_state && dark), .hit(dark_hit)
  );

  rlc_debounce #(.LEN(DARK_CNT)) u_light_db (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .step(acc),
    .cond((state_q == ST_FAULT) && !dark), .hit(light_hit)
  );

  rlc_debounce #(.LEN(FS_CNT)) u_fs_db (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .step(acc),
    .cond((state_q == ST_MON) && !dark && !jump && below && (dac_q == DMAX)),
    .hit(fs_hit)
  );

  rlc_min_track #(.DAC_W(DAC_W), .ADC_W(ADC_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .clear(trk_clr), .update(trk_upd),
    .code(dac_q), .sample(sample_data),
    .best_code(best_code), .best_val(best_val)
  );

  // ---------------- next state ----------------
  always_comb begin
    state_d  = state_q;
    dac_d    = dac_q;
    ref_d    = ref_q;
    calmin_d = calmin_q;
    winhi_d  = winhi_q;
    cnt_d    = cnt_q;
    settle_d = settle_q;
    heat_d   = heat_q;
    trk_clr  = 1'b0;

    if (!enable) begin
      state_d  = ST_RESET;
      dac_d    = '0;
      settle_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_RESET: begin
          state_d = ST_CAL;
          dac_d   = '0;
          trk_clr = 1'b1;
        end

        ST_CAL: if (acc) begin
          if (dark_hit) begin
            state_d = ST_FAULT; heat_d = 1'b0; dac_d = '0;
          end else if (!dark) begin
            if (cal_last) begin
              state_d  = ST_LOCK;
              dac_d    = add_sat(best_code, DET_E);
              calmin_d = best_val;
              cnt_d    = '0;
            end else begin
              dac_d = dac_q + STEP_E[DAC_W-1:0];
            end
          end
        end

        ST_LOCK: if (acc) begin
          if (dark_hit) begin
            state_d = ST_FAULT; heat_d = 1'b0; dac_d = '0;
          end else if (!dark) begin
            if (cnt_q == SET_LAST) begin
              ref_d   = sample_data;
              state_d = ST_MON;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end

        ST_MON: if (acc) begin
          if (dark_hit) begin
            state_d = ST_FAULT; heat_d = 1'b0; dac_d = '0;
          end else if (!dark) begin
            if (fs_hit) begin
              state_d = ST_FAULT; heat_d = 1'b1; dac_d = '0;
            end else if (jump) begin
              state_d  = ST_RELOCK;
              dac_d    = win_lo;
              winhi_d  = win_hi;
              settle_d = 1'b0;
              trk_clr  = 1'b1;
            end else if (below && (dac_q != DMAX)) begin
              dac_d = dac_q + 1'b1;
            end else if (above && (dac_q != '0)) begin
              dac_d = dac_q - 1'b1;
            end
          end
        end

        ST_RELOCK: if (acc) begin
          if (dark_hit) begin
            state_d = ST_FAULT; heat_d = 1'b0; dac_d = '0; settle_d = 1'b0;
          end else if (!dark) begin
            if (settle_q) begin
              if (cnt_q == SET_LAST) begin
                ref_d    = sample_data;
                state_d  = ST_MON;
                settle_d = 1'b0;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end else if (dac_q == winhi_q) begin
              if (relock_ok) begin
                dac_d    = add_sat(best_code, DET_E);
                settle_d = 1'b1;
                cnt_d    = '0;
              end else begin
                state_d = ST_CAL;
                dac_d   = '0;
                trk_clr = 1'b1;
              end
            end else begin
              dac_d = dac_q + 1'b1;
            end
          end
        end

        ST_FAULT: begin
          dac_d = '0;
          if (fault_clear) begin
            state_d = ST_RESET;
          end else if (!heat_q && light_hit) begin
            state_d = ST_CAL;
            trk_clr = 1'b1;
          end
        end

        default: begin
          state_d = ST_RESET;
          dac_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_RESET;
      dac_q    <= '0;
      ref_q    <= '0;
      calmin_q <= '0;
      winhi_q  <= '0;
      cnt_q    <= '0;
      settle_q <= 1'b0;
      heat_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      dac_q    <= dac_d;
      ref_q    <= ref_d;
      calmin_q <= calmin_d;
      winhi_q  <= winhi_d;
      cnt_q    <= cnt_d;
      settle_q <= settle_d;
      heat_q   <= heat_d;
    end
  end

  assign dac_code     = dac_q;
  assign state_o      = state_q;
  assign locked       = (state_q == ST_MON);
  assign fault_dark   = (state_q == ST_FAULT) && !heat_q;
  assign fault_heater = (state_q == ST_FAULT) && heat_q;
endmodule

// File: rtl/rlc_checker.sv
module rlc_checker #(
  parameter int DAC_W    = 6,
  parameter int CAL_STEP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             sample_valid,
  input logic [DAC_W-1:0] dac_code,
  input logic [2:0]       state_o,
  input logic             locked,
  input logic             fault_dark,
  input logic             fault_heater
);
  // R12: the heater is off whenever the controller sits in FAULT
  assert_fault_safe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5) |-> (dac_code == '0));

  // R1: a low enable parks the loop at the next edge
  assert_enable_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ((state_o == 3'd0) && (dac_code == '0)));

  // R2: no sample, no movement in the running states
  assert_hold_no_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !sample_valid && (state_o inside {3'd1, 3'd2, 3'd3, 3'd4}))
      |=> ($stable(dac_code) && $stable(state_o)));

  // R3: inside CALIBRATE the code only moves by the sweep step
  assert_sweep_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd1) && ($past(state_o) == 3'd1) && (dac_code != $past(dac_code)))
      |-> (int'(dac_code) == int'($past(dac_code)) + CAL_STEP));

  // R5: tracking moves the code by at most one per cycle
  assert_track_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd3) && ($past(state_o) == 3'd3))
      |-> ((int'(dac_code) - int'($past(dac_code)) <= 1) &&
           (int'($past(dac_code)) - int'(dac_code) <= 1)));

  // R4: lock indication only in MONITOR, and flags exclusive
  assert_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({locked, fault_dark, fault_heater}) && (!locked || (state_o == 3'd3)));
endmodule

bind ring_lock_ctrl rlc_checker #(.DAC_W(DAC_W), .CAL_STEP(CAL_STEP)) u_rlc_checker (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sample_valid(sample_valid),
  .dac_code(dac_code), .state_o(state_o), .locked(locked),
  .fault_dark(fault_dark), .fault_heater(fault_heater)
);

// File: tb/tb_ring_lock_ctrl.sv
`timescale 1ns/1ps
module tb_ring_lock_ctrl;
  localparam int DW = 6;
  localparam int AW = 8;
  localparam int FULL = 63;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          sample_valid = 1'b1;
  logic          sample_ready;
  logic [AW-1:0] sample_data;
  logic          fault_clear = 1'b0;
  logic [DW-1:0] dac_code;
  logic [2:0]    state_o;
  logic          locked, fault_dark, fault_heater;

  int notch = 23;
  int floor_lvl = 20;
  bit light = 1'b1;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // Resonance model: V-shaped dip, 6 counts per code, clipped at 255.
  function automatic int plant(input int code, input int n, input int fl);
    int d;
    int v;
    d = code - n;
    if (d < 0) d = -d;
    v = fl + 6 * d;
    return (v > 255) ? 255 : v;
  endfunction

  always_comb begin
    if (light) sample_data = AW'(plant(int'(dac_code), notch, floor_lvl));
    else       sample_data = AW'(2);
  end

  ring_lock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sample_valid(sample_valid),
    .sample_ready(sample_ready), .sample_data(sample_data),
    .fault_clear(fault_clear), .dac_code(dac_code), .state_o(state_o),
    .locked(locked), .fault_dark(fault_dark), .fault_heater(fault_heater)
  );

  function automatic int exp_lock(input int n, input int fl);
    int best;
    int bc;
    best = 1000;
    bc = 0;
    for (int c = 0; c <= FULL; c += 4) begin
      if (plant(c, n, fl) < best) begin
        best = plant(c, n, fl);
        bc = c;
      end
    end
    return (bc + 3 > FULL) ? FULL : bc + 3;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_sd(input string tag, input int st, input int code);
    chk({tag, " state"}, int'(state_o), st);
    chk({tag, " code"}, int'(dac_code), code);
  endtask

  task automatic restart(input int n);
    enable = 1'b0;
    step(1);
    notch = n;
    enable = 1'b1;
  endtask

  initial begin
    step(3);
    // R1: reset state
    chk_sd("R1 reset", 0, 0);
    chk("R1 ready low", int'(sample_ready), 0);
    chk("R1 flags", int'({locked, fault_dark, fault_heater}), 0);
    rst_n = 1'b1;
    step(2);
    chk_sd("R1 enable low", 0, 0);

    // R3 R4: calibration with the dip at every code position
    for (int n = 0; n <= FULL; n++) begin
      restart(n);
      step(16);
      chk_sd("R3 last sweep code", 1, 60);
      step(1);
      chk_sd("R3 lock code", 2, exp_lock(n, floor_lvl));
      step(2);
      chk_sd("R4 monitor entry", 3, exp_lock(n, floor_lvl));
      chk("R4 locked flag", int'(locked), 1);
    end

    // R2: stalled stream holds the sweep
    restart(23);
    step(5);
    chk_sd("R2 sweep midway", 1, 16);
    chk("R2 ready follows enable", int'(sample_ready), 1);
    sample_valid = 1'b0;
    step(5);
    chk_sd("R2 no sample hold", 1, 16);
    sample_valid = 1'b1;
    step(12);
    chk_sd("R3 lock after stall", 2, 27);
    step(2);
    chk_sd("R4 monitor after stall", 3, 27);

    // R5: long steady hold, then drift both ways
    step(300);
    chk_sd("R5 steady hold", 3, 27);
    notch = 24; step(2); chk_sd("R5 drift up", 3, 28);
    notch = 25; step(2); chk_sd("R5 drift up 2", 3, 29);
    notch = 24; step(2); chk_sd("R5 drift down", 3, 28);
    notch = 23; step(2); chk_sd("R5 drift back", 3, 27);

    // R9 R5: brownout - short dark spell plus small shift
    light = 1'b0; step(2);
    chk_sd("R9 short dark ignored", 3, 27);
    chk("R9 no dark fault", int'(fault_dark), 0);
    light = 1'b1; notch = 24; step(3);
    chk_sd("R5 dip retune", 3, 28);
    notch = 23; step(3);
    chk_sd("R5 dip recovered", 3, 27);

    // R6 R7: jump with dip inside the window
    notch = 33; step(1);
    chk_sd("R6 jump to relock", 4, 21);
    step(13);
    chk_sd("R7 relock settling", 4, 36);
    step(2);
    chk_sd("R7 back to monitor", 3, 36);

    // R6 R8: jump far outside the window
    notch = 55; step(1);
    chk_sd("R6 far jump", 4, 30);
    step(13);
    chk_sd("R8 fallback to calibrate", 1, 0);
    step(16);
    chk_sd("R8 recal lock", 2, exp_lock(55, floor_lvl));
    step(2);
    chk_sd("R8 recal monitor", 3, 59);

    // R6 R7: window clamped at full scale, detune saturates
    notch = 65; step(1);
    chk_sd("R6 clamped window start", 4, 53);
    step(13);
    chk_sd("R7 saturated relock", 3, 63);

    // R11: heater pinned at full scale
    notch = 64; step(3);
    chk_sd("R11 before debounce", 3, 63);
    step(1);
    chk_sd("R11 heater fault", 5, 0);
    chk("R11 heater flag", int'(fault_heater), 1);
    step(10);
    chk_sd("R11 fault held with light", 5, 0);
    fault_clear = 1'b1; step(1);
    chk_sd("R11 clear to reset", 0, 0);
    fault_clear = 1'b0; step(1);
    chk_sd("R1 reset to calibrate", 1, 0);

    // R9 R10: loss of light and return at a new level
    restart(23);
    step(19);
    chk_sd("R9 locked before dark", 3, 27);
    light = 1'b0; step(2);
    chk_sd("R9 dark below count", 3, 27);
    step(1);
    chk_sd("R9 dark fault", 5, 0);
    chk("R9 dark flag", int'(fault_dark), 1);
    step(10);
    chk_sd("R9 stays dark", 5, 0);
    floor_lvl = 30; light = 1'b1; step(2);
    chk_sd("R10 light below count", 5, 0);
    step(1);
    chk_sd("R10 recalibrate", 1, 0);
    step(16);
    chk_sd("R10 relock after light", 2, exp_lock(23, 30));
    step(2);
    chk_sd("R10 monitor after light", 3, 27);

    // R1: enable dropped while running
    enable = 1'b0; step(1);
    chk_sd("R1 disable", 0, 0);
    chk("R1 ready off", int'(sample_ready), 0);
    chk("R1 locked off", int'(locked), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 150000 cycles expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule